// File: doc/BRIEF.md
# Two-Channel DMA Transfer Controller

This block moves data between memory and I/O space on behalf of the processor. It has two channels with identical function. Each channel holds its own source pointer, destination pointer, transfer count and mode word. All of these are loaded through one write-only register port. A channel is armed by setting its run bit. It then waits for a trigger, which comes from its external request pin, from a timer pulse, or from the software setting (no request needed).

Each transfer starts with a bus-hold request. The channel waits for the bus owner's acknowledge before it drives anything. It then reads one element from the source into an internal holding register and writes that element to the destination. After that it steps the pointers, decrements the count and releases hold. The element size is byte or word. Each pointer chooses its own address space and its own step direction.

In source-synchronized mode the trigger starts the whole transfer. In destination-synchronized mode the read is done as soon as the channel is armed, and the write waits for the trigger. A terminal-count option stops the channel when its count reaches zero, and can pulse an interrupt line for that channel.

Top module: `dual_dma_ctrl`

## Requirements
- R1: The register port writes the register picked by `regSel` (0 source pointer, 1 destination pointer, 2 count, 3 mode word) of the channel picked by `regChan`. Each channel keeps its own set and runs from it.
- R2: Mode bit 0 arms the channel, and mode bits 2:1 choose the trigger. 0 is the external pin: a level, passed through a two-flop synchronizer, where a one-cycle pulse gives one transfer. 1 is the channel's timer pulse: each pulse allows one transfer. 2 is software: transfers repeat with no request. No transfer happens while the chosen trigger is absent.
- R3: `busRead` and `busWrite` are asserted only while `busHold` and `holdAck` are both high. Once `busHold` falls it stays low for at least one cycle.
- R4: Each transfer is one read at the source address followed by one write of the value that was read to the destination address. A bus phase holds its strobe and address until `busReady`.
- R5: Mode bit 4 selects word elements, with a pointer step of 2; otherwise elements are bytes, with a step of 1. A byte write carries the low byte of the read data, with the upper bits zero. Mode bits 6:5 (source) and 9:8 (destination) choose 0 hold, 1 increment, 2 decrement.
- R6: Mode bit 7 places the source in I/O space and mode bit 10 places the destination in I/O space. `busIo` reflects the space of the address being driven.
- R7: With mode bit 3 set (destination-synchronized), an armed channel reads without waiting for its trigger. It then keeps the bus held and does not write until the trigger is present.
- R8: With mode bit 11 set, the channel clears its run bit after the write that brings the count to zero. An armed channel whose count is already zero starts nothing. With bit 11 clear, the count wraps and the channel keeps running.
- R9: With mode bits 11 and 12 both set, the channel's `irq` line pulses high for one cycle when the count ends. With bit 12 clear, it never pulses.
- R10: When both channels are ready at once, the one with mode bit 13 set wins. When the bits are equal, the channels take turns.
- R11: After reset, `busHold`, `busRead`, `busWrite` and `irq` are all low.
- R12: Clearing the run bit stops the channel once its current transfer is finished. No further transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regChan | input | 1 | Channel addressed by the write |
| regSel | input | 2 | Register addressed by the write |
| regWdata | input | ADDR_W | Write data |
| extReq | input | 2 | External request pins, one per channel |
| timerTick | input | 2 | Timer trigger pulses, one per channel |
| busHold | output | 1 | Bus hold request |
| holdAck | input | 1 | Bus hold acknowledge |
| busRead | output | 1 | Read phase strobe |
| busWrite | output | 1 | Write phase strobe |
| busAddr | output | ADDR_W | Bus address |
| busIo | output | 1 | High when the address is in I/O space |
| busWord | output | 1 | High for word elements |
| busWdata | output | DATA_W | Write data |
| busRdata | input | DATA_W | Read data |
| busReady | input | 1 | Ends the current bus phase |
| irq | output | 2 | Terminal-count interrupt pulses |

## Verification
The hardest situations to reach from the ports are the two arbitration outcomes. They only occur when both channels become ready in the same idle cycle. The stimulus arms one channel a couple of cycles before the other, so the second channel is waiting by the time the first finishes its transfer. From there every later arbitration involves both channels, and the order of destination addresses in the write log shows whether the channels alternated or the high-priority channel ran to completion. The destination-synchronized stall is reached by arming the channel with its pin low. The bench then confirms that a read has happened, that no write has happened, and that hold is still asserted, before it raises the pin.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    TRIG_EXT   = 2'd0,
    TRIG_TIMER = 2'd1,
    TRIG_SOFT  = 2'd2,
    TRIG_NONE  = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_RSVD = 2'd3
  } step_e;

  // mode word, bit 13 down to bit 0
  typedef struct packed {
    logic  prioHigh;
    logic  irqEn;
    logic  tcStop;
    logic  dstIo;
    step_e dstStep;
    logic  srcIo;
    step_e srcStep;
    logic  wordSize;
    logic  destSync;
    trig_e trig;
    logic  run;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);

  // subset of the mode word the sequencer needs
  typedef struct packed {
    logic  prioHigh;
    logic  tcStop;
    logic  destSync;
    trig_e trig;
    logic  run;
  } chan_mode_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic chanSel;
    logic latchData;
    logic advSrc;
    logic advDst;
    logic decCount;
  } dp_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_READ  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_WRITE = 3'd4,
    ST_DONE  = 3'd5
  } dma_state_e;
endpackage

// File: rtl/dma_datapath.sv
`timescale 1ns/1ps
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic                    regChan,
  input  logic [1:0]              regSel,
  input  logic [ADDR_W-1:0]       regWdata,
  input  dp_strobe_t              strobe,
  input  logic                    phaseWrite,
  input  logic [DATA_W-1:0]       busRdata,
  output chan_mode_t [NUM_CH-1:0] chMode,
  output logic [NUM_CH-1:0]       cntZero,
  output logic [ADDR_W-1:0]       busAddr,
  output logic                    busIo,
  output logic                    busWord,
  output logic [DATA_W-1:0]       busWdata,
  output logic [NUM_CH-1:0]       irq
);
  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CFG = 2'd3;
  localparam int         PAD_W   = DATA_W - 8;

  function automatic logic [ADDR_W-1:0] stepPtr(input logic [ADDR_W-1:0] ptr,
                                                input step_e mode, input logic wide);
    logic [ADDR_W-1:0] amt;
    amt = wide ? ADDR_W'(2) : ADDR_W'(1);
    case (mode)
      STEP_INC: return ptr + amt;
      STEP_DEC: return ptr - amt;
      default:  return ptr;
    endcase
  endfunction

  logic [ADDR_W-1:0] srcArr [NUM_CH];
  logic [ADDR_W-1:0] dstArr [NUM_CH];
  chan_cfg_t         cfgArr [NUM_CH];
  logic [DATA_W-1:0] holdReg;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [ADDR_W-1:0] srcPtr;
    logic [ADDR_W-1:0] dstPtr;
    logic [CNT_W-1:0]  count;
    chan_cfg_t         cfg;
    logic              irqPulse;
    logic              hit;
    logic              mine;

    assign hit  = regWe && (regChan == 1'(c));
    assign mine = strobe.chanSel == 1'(c);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcPtr   <= '0;
        dstPtr   <= '0;
        count    <= '0;
        cfg      <= '0;
        irqPulse <= 1'b0;
      end else begin
        irqPulse <= 1'b0;
        if (hit) begin
          case (regSel)
            SEL_SRC: srcPtr <= regWdata;
            SEL_DST: dstPtr <= regWdata;
            SEL_CNT: count  <= regWdata[CNT_W-1:0];
            SEL_CFG: cfg    <= chan_cfg_t'(regWdata[CFG_W-1:0]);
            default: ;
          endcase
        end else if (mine) begin
          if (strobe.advSrc) srcPtr <= stepPtr(srcPtr, cfg.srcStep, cfg.wordSize);
          if (strobe.advDst) dstPtr <= stepPtr(dstPtr, cfg.dstStep, cfg.wordSize);
          if (strobe.decCount) begin
            count <= count - CNT_W'(1);
            if (cfg.tcStop && count == CNT_W'(1)) begin
              cfg.run  <= 1'b0;
              irqPulse <= cfg.irqEn;
            end
          end
        end
      end
    end

    assign srcArr[c]          = srcPtr;
    assign dstArr[c]          = dstPtr;
    assign cfgArr[c]          = cfg;
    assign cntZero[c]         = count == '0;
    assign irq[c]             = irqPulse;
    assign chMode[c].prioHigh = cfg.prioHigh;
    assign chMode[c].tcStop   = cfg.tcStop;
    assign chMode[c].destSync = cfg.destSync;
    assign chMode[c].trig     = cfg.trig;
    assign chMode[c].run      = cfg.run;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 holdReg <= '0;
    else if (strobe.latchData) holdReg <= busRdata;
  end

  chan_cfg_t curCfg;
  assign curCfg   = cfgArr[strobe.chanSel];
  assign busAddr  = phaseWrite ? dstArr[strobe.chanSel] : srcArr[strobe.chanSel];
  assign busIo    = phaseWrite ? curCfg.dstIo : curCfg.srcIo;
  assign busWord  = curCfg.wordSize;
  assign busWdata = curCfg.wordSize ? holdReg : {{PAD_W{1'b0}}, holdReg[7:0]};
endmodule

// File: rtl/dma_control.sv
`timescale 1ns/1ps
module dma_control
  import dma_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  chan_mode_t [NUM_CH-1:0] chMode,
  input  logic [NUM_CH-1:0]       cntZero,
  input  logic [NUM_CH-1:0]       extReq,
  input  logic [NUM_CH-1:0]       timerTick,
  input  logic                    holdAck,
  input  logic                    busReady,
  output dp_strobe_t              strobe,
  output logic                    phaseWrite,
  output logic                    busHold,
  output logic                    busRead,
  output logic                    busWrite
);
  dma_state_e        state;
  logic              curCh;
  logic              lastCh;
  logic              pick;
  logic              grant;
  logic [NUM_CH-1:0] syncA;
  logic [NUM_CH-1:0] syncB;
  logic [NUM_CH-1:0] timerPend;
  logic [NUM_CH-1:0] reqActive;
  logic [NUM_CH-1:0] want;
  logic [NUM_CH-1:0] consume;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= extReq;
      syncB <= syncA;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_req
    logic eligible;

    always_comb begin
      case (chMode[c].trig)
        TRIG_EXT:   reqActive[c] = syncB[c];
        TRIG_TIMER: reqActive[c] = timerPend[c];
        TRIG_SOFT:  reqActive[c] = 1'b1;
        default:    reqActive[c] = 1'b0;
      endcase
    end

    assign eligible = chMode[c].run && (chMode[c].trig != TRIG_NONE)
                      && !(chMode[c].tcStop && cntZero[c]);
    assign want[c]  = eligible && (chMode[c].destSync || reqActive[c]);

    assign consume[c] =
        (state == ST_IDLE && grant && pick == 1'(c) && !chMode[c].destSync) ||
        (state == ST_WAIT && curCh == 1'(c) && chMode[c].run && reqActive[c]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) timerPend[c] <= 1'b0;
      else       timerPend[c] <= chMode[c].run && (chMode[c].trig == TRIG_TIMER)
                                 && (timerTick[c] || (timerPend[c] && !consume[c]));
    end
  end

  assign grant = |want;

  always_comb begin
    if (want[0] && want[1]) begin
      if (chMode[0].prioHigh != chMode[1].prioHigh) pick = chMode[1].prioHigh;
      else                                          pick = ~lastCh;
    end else begin
      pick = want[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      curCh  <= 1'b0;
      lastCh <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (grant) begin
          curCh  <= pick;
          lastCh <= pick;
          state  <= ST_HOLD;
        end
        ST_HOLD: if (holdAck) state <= ST_READ;
        ST_READ: if (busReady) state <= chMode[curCh].destSync ? ST_WAIT : ST_WRITE;
        ST_WAIT: begin
          if (!chMode[curCh].run)     state <= ST_DONE;
          else if (reqActive[curCh])  state <= ST_WRITE;
        end
        ST_WRITE: if (busReady) state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.chanSel   = curCh;
    strobe.latchData = (state == ST_READ) && busReady;
    strobe.advSrc    = (state == ST_READ) && busReady;
    strobe.advDst    = (state == ST_WRITE) && busReady;
    strobe.decCount  = (state == ST_WRITE) && busReady;
  end

  assign phaseWrite = state == ST_WRITE;
  assign busRead    = state == ST_READ;
  assign busWrite   = state == ST_WRITE;
  assign busHold    = (state == ST_HOLD) || (state == ST_READ) ||
                      (state == ST_WAIT) || (state == ST_WRITE);
endmodule

// File: rtl/dual_dma_ctrl.sv
`timescale 1ns/1ps
module dual_dma_ctrl
  import dma_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regChan,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic [1:0]        extReq,
  input  logic [1:0]        timerTick,
  output logic              busHold,
  input  logic              holdAck,
  output logic              busRead,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busIo,
  output logic              busWord,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic [1:0]        irq
);
  chan_mode_t [NUM_CH-1:0] chMode;
  logic [NUM_CH-1:0]       cntZero;
  dp_strobe_t              strobe;
  logic                    phaseWrite;

  dma_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chMode     (chMode),
    .cntZero    (cntZero),
    .extReq     (extReq),
    .timerTick  (timerTick),
    .holdAck    (holdAck),
    .busReady   (busReady),
    .strobe     (strobe),
    .phaseWrite (phaseWrite),
    .busHold    (busHold),
    .busRead    (busRead),
    .busWrite   (busWrite)
  );

  dma_datapath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regChan    (regChan),
    .regSel     (regSel),
    .regWdata   (regWdata),
    .strobe     (strobe),
    .phaseWrite (phaseWrite),
    .busRdata   (busRdata),
    .chMode     (chMode),
    .cntZero    (cntZero),
    .busAddr    (busAddr),
    .busIo      (busIo),
    .busWord    (busWord),
    .busWdata   (busWdata),
    .irq        (irq)
  );
endmodule

// File: rtl/dma_checker.sv
`timescale 1ns/1ps
module dma_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              busHold,
  input logic              holdAck,
  input logic              busRead,
  input logic              busWrite,
  input logic              busReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        irq
);
  p_cycle_needs_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busRead || busWrite) |-> (busHold && holdAck));

  p_read_after_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRead) |-> $past(busHold));

  p_hold_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busHold) |=> !busHold);

  p_single_phase_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(busRead && busWrite));

  p_write_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && !busReady) |=> (busWrite && $stable(busAddr)));

  p_read_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && !busReady) |=> (busRead && $stable(busAddr)));

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|irq) |=> !(|irq));
endmodule

bind dual_dma_ctrl dma_checker #(.ADDR_W(ADDR_W)) u_dmaChk (
  .clk      (clk),
  .rstN     (rstN),
  .busHold  (busHold),
  .holdAck  (holdAck),
  .busRead  (busRead),
  .busWrite (busWrite),
  .busReady (busReady),
  .busAddr  (busAddr),
  .irq      (irq)
);

// File: tb/dual_dma_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_dma_ctrl_tb_top;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int LOG_N  = 64;
  localparam int NVEC   = 6;

  // mode word values: run, software trigger, terminal count, plus per-vector fields
  localparam logic [13:0] VEC_CFG [NVEC] = '{14'h0925, 14'h1935, 14'h09D5,
                                             14'h0985, 14'h0E35, 14'h0C85};
  localparam logic [ADDR_W-1:0] VEC_SRC [NVEC] = '{20'h00100, 20'h00120, 20'h00140,
                                                   20'h00033, 20'h00160, 20'h00077};
  localparam logic [ADDR_W-1:0] VEC_DST [NVEC] = '{20'h00800, 20'h00820, 20'h00840,
                                                   20'h00860, 20'h00880, 20'h000A0};

  logic              clk = 1'b0;
  logic              rstN;
  logic              regWe;
  logic              regChan;
  logic [1:0]        regSel;
  logic [ADDR_W-1:0] regWdata;
  logic [1:0]        extReq;
  logic [1:0]        timerTick;
  logic              busHold;
  logic              holdAck;
  logic              busRead;
  logic              busWrite;
  logic [ADDR_W-1:0] busAddr;
  logic              busIo;
  logic              busWord;
  logic [DATA_W-1:0] busWdata;
  logic [DATA_W-1:0] busRdata;
  logic              busReady;
  logic [1:0]        irq;

  always #2.5 clk = ~clk;

  dual_dma_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regChan(regChan), .regSel(regSel),
    .regWdata(regWdata), .extReq(extReq), .timerTick(timerTick), .busHold(busHold),
    .holdAck(holdAck), .busRead(busRead), .busWrite(busWrite), .busAddr(busAddr),
    .busIo(busIo), .busWord(busWord), .busWdata(busWdata), .busRdata(busRdata),
    .busReady(busReady), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int protoErr = 0;
  int irqCnt0 = 0;
  int irqCnt1 = 0;
  int wrCnt = 0;
  int rdCnt = 0;
  logic [ADDR_W-1:0] wrAddr [LOG_N];
  logic              wrIo   [LOG_N];
  logic [DATA_W-1:0] wrData [LOG_N];
  logic [ADDR_W-1:0] rdAddr [LOG_N];
  logic              rdIo   [LOG_N];

  function automatic logic [DATA_W-1:0] modelData(input logic [ADDR_W-1:0] a, input logic io);
    return {a[7:0] ^ 8'h3C, a[7:0]} ^ (io ? 16'hA5A5 : 16'h0000);
  endfunction

  function automatic int stepOf(input logic [1:0] mode, input logic wide);
    int amt;
    amt = wide ? 2 : 1;
    if (mode == 2'd1) return amt;
    if (mode == 2'd2) return -amt;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic ch, input logic [1:0] sel, input logic [ADDR_W-1:0] d);
    @(negedge clk);
    regWe = 1'b1; regChan = ch; regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearLogs();
    wrCnt = 0;
    rdCnt = 0;
  endtask

  // bus owner and memory model: acknowledges hold, one wait cycle per phase
  initial begin
    holdAck = 1'b0; busReady = 1'b0; busRdata = '0;
    forever begin
      @(negedge clk);
      if ((busRead || busWrite) && !(busHold && holdAck)) protoErr++;
      if (irq[0]) irqCnt0++;
      if (irq[1]) irqCnt1++;
      holdAck = busHold;
      if ((busRead || busWrite) && !busReady) begin
        busReady = 1'b1;
        if (busRead) begin
          busRdata = modelData(busAddr, busIo);
          if (rdCnt < LOG_N) begin rdAddr[rdCnt] = busAddr; rdIo[rdCnt] = busIo; end
          rdCnt++;
        end else begin
          if (wrCnt < LOG_N) begin
            wrAddr[wrCnt] = busAddr; wrIo[wrCnt] = busIo; wrData[wrCnt] = busWdata;
          end
          wrCnt++;
        end
      end else begin
        busReady = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWe = 1'b0; regChan = 1'b0; regSel = '0; regWdata = '0;
    extReq = '0; timerTick = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    chk(!busHold && !busRead && !busWrite && irq == 2'b00, "R11 reset outputs",
        {busHold, busRead, busWrite, irq}, 0);

    // vector table: element size, steps and spaces, two transfers each
    for (int v = 0; v < NVEC; v++) begin
      automatic logic [13:0] cf = VEC_CFG[v];
      automatic int irqBase = irqCnt0;
      automatic int sStep = stepOf(cf[6:5], cf[4]);
      automatic int dStep = stepOf(cf[9:8], cf[4]);
      clearLogs();
      regWrite(1'b0, 2'd0, VEC_SRC[v]);
      regWrite(1'b0, 2'd1, VEC_DST[v]);
      regWrite(1'b0, 2'd2, 20'd2);
      regWrite(1'b0, 2'd3, {6'd0, cf});
      waitCyc(60);
      chk(wrCnt == 2 && rdCnt == 2, "R8 stop after count", wrCnt, 2);
      for (int k = 0; k < 2; k++) begin
        automatic logic [ADDR_W-1:0] eSrc = VEC_SRC[v] + ADDR_W'(k * sStep);
        automatic logic [ADDR_W-1:0] eDst = VEC_DST[v] + ADDR_W'(k * dStep);
        automatic logic [DATA_W-1:0] eDat = modelData(eSrc, cf[7]);
        if (!cf[4]) eDat = {8'h00, eDat[7:0]};
        chk(rdAddr[k] == eSrc, "R5 source address", rdAddr[k], eSrc);
        chk(rdIo[k] == cf[7], "R6 source space", rdIo[k], cf[7]);
        chk(wrAddr[k] == eDst, "R5 destination address", wrAddr[k], eDst);
        chk(wrIo[k] == cf[10], "R6 destination space", wrIo[k], cf[10]);
        chk(wrData[k] == eDat, "R4 data copied", wrData[k], eDat);
      end
      chk(irqCnt0 - irqBase == int'(cf[12]), "R9 irq enable", irqCnt0 - irqBase, cf[12]);
    end

    // count already zero with terminal count: nothing starts
    clearLogs();
    regWrite(1'b0, 2'd2, 20'd0);
    regWrite(1'b0, 2'd3, 20'h00925);
    waitCyc(30);
    chk(wrCnt == 0 && rdCnt == 0, "R8 zero count idle", rdCnt + wrCnt, 0);
    regWrite(1'b0, 2'd3, 20'h00000);

    // external pin trigger on channel 1
    begin
      automatic int irqBase = irqCnt1;
      clearLogs();
      regWrite(1'b1, 2'd0, 20'h00040);
      regWrite(1'b1, 2'd1, 20'h00900);
      regWrite(1'b1, 2'd2, 20'd3);
      regWrite(1'b1, 2'd3, 20'h01931);
      waitCyc(20);
      chk(wrCnt == 0 && !busHold, "R2 no pin no transfer", wrCnt, 0);
      @(negedge clk) extReq[1] = 1'b1;
      @(negedge clk) extReq[1] = 1'b0;
      waitCyc(30);
      chk(wrCnt == 1, "R2 pin pulse gives one transfer", wrCnt, 1);
      chk(wrAddr[0] == 20'h00900, "R1 channel 1 destination", wrAddr[0], 20'h00900);
      @(negedge clk) extReq[1] = 1'b1;
      waitCyc(60);
      chk(wrCnt == 3, "R8 pin level stops at count", wrCnt, 3);
      chk(irqCnt1 - irqBase == 1, "R9 irq pulse at end", irqCnt1 - irqBase, 1);
      @(negedge clk) extReq[1] = 1'b0;
    end

    // timer trigger on channel 0
    begin
      automatic int irqBase = irqCnt0;
      clearLogs();
      regWrite(1'b0, 2'd0, 20'h00010);
      regWrite(1'b0, 2'd1, 20'h00A00);
      regWrite(1'b0, 2'd2, 20'd2);
      regWrite(1'b0, 2'd3, 20'h01933);
      waitCyc(20);
      chk(wrCnt == 0, "R2 no tick no transfer", wrCnt, 0);
      @(negedge clk) timerTick[0] = 1'b1;
      @(negedge clk) timerTick[0] = 1'b0;
      waitCyc(30);
      chk(wrCnt == 1, "R2 one tick one transfer", wrCnt, 1);
      chk(irqCnt0 == irqBase, "R9 no irq before end", irqCnt0 - irqBase, 0);
      @(negedge clk) timerTick[0] = 1'b1;
      @(negedge clk) timerTick[0] = 1'b0;
      waitCyc(30);
      chk(wrCnt == 2 && irqCnt0 - irqBase == 1, "R9 irq after second tick", irqCnt0 - irqBase, 1);
      @(negedge clk) timerTick[0] = 1'b1;
      @(negedge clk) timerTick[0] = 1'b0;
      waitCyc(30);
      chk(wrCnt == 2, "R8 stopped channel ignores tick", wrCnt, 2);
    end

    // destination-synchronized stall on channel 1
    clearLogs();
    regWrite(1'b1, 2'd0, 20'h00050);
    regWrite(1'b1, 2'd1, 20'h00B00);
    regWrite(1'b1, 2'd2, 20'd1);
    regWrite(1'b1, 2'd3, 20'h00939);
    waitCyc(30);
    chk(rdCnt == 1, "R7 read without request", rdCnt, 1);
    chk(wrCnt == 0, "R7 write waits for request", wrCnt, 0);
    chk(busHold == 1'b1, "R7 bus kept during wait", busHold, 1);
    @(negedge clk) extReq[1] = 1'b1;
    waitCyc(30);
    chk(wrCnt == 1 && wrAddr[0] == 20'h00B00, "R7 write after request", wrAddr[0], 20'h00B00);
    chk(wrData[0] == modelData(20'h00050, 1'b0), "R4 data through wait", wrData[0],
        modelData(20'h00050, 1'b0));
    @(negedge clk) extReq[1] = 1'b0;

    // equal priority: channels alternate
    clearLogs();
    regWrite(1'b0, 2'd0, 20'h00000); regWrite(1'b0, 2'd1, 20'h00200); regWrite(1'b0, 2'd2, 20'd2);
    regWrite(1'b1, 2'd0, 20'h00010); regWrite(1'b1, 2'd1, 20'h00300); regWrite(1'b1, 2'd2, 20'd2);
    regWrite(1'b0, 2'd3, 20'h00925);
    regWrite(1'b1, 2'd3, 20'h00925);
    waitCyc(80);
    chk(wrCnt == 4, "R10 equal transfers done", wrCnt, 4);
    chk(wrAddr[0] == 20'h00200 && wrAddr[1] == 20'h00300, "R10 alternate first pair",
        {wrAddr[0][11:0], wrAddr[1][11:0]}, 32'h00200300);
    chk(wrAddr[2] == 20'h00201 && wrAddr[3] == 20'h00301, "R1 R10 alternate second pair",
        {wrAddr[2][11:0], wrAddr[3][11:0]}, 32'h00201301);

    // channel 1 has priority
    clearLogs();
    regWrite(1'b0, 2'd1, 20'h00200); regWrite(1'b0, 2'd2, 20'd2);
    regWrite(1'b1, 2'd1, 20'h00300); regWrite(1'b1, 2'd2, 20'd2);
    regWrite(1'b0, 2'd3, 20'h00925);
    regWrite(1'b1, 2'd3, 20'h02925);
    waitCyc(80);
    chk(wrCnt == 4, "R10 priority transfers done", wrCnt, 4);
    chk(wrAddr[1] == 20'h00300 && wrAddr[2] == 20'h00301, "R10 high priority runs",
        {wrAddr[1][11:0], wrAddr[2][11:0]}, 32'h00300301);
    chk(wrAddr[3] == 20'h00201, "R10 low priority last", wrAddr[3], 20'h00201);

    // no terminal count: runs until run bit cleared
    begin
      automatic int snap;
      clearLogs();
      regWrite(1'b0, 2'd1, 20'h00400);
      regWrite(1'b0, 2'd2, 20'd1);
      regWrite(1'b0, 2'd3, 20'h00125);
      waitCyc(80);
      chk(wrCnt >= 3, "R8 keeps running without terminal count", wrCnt, 3);
      regWrite(1'b0, 2'd3, 20'h00124);
      snap = wrCnt;
      waitCyc(30);
      chk(wrCnt <= snap + 1, "R12 at most current transfer finishes", wrCnt, snap + 1);
      snap = wrCnt;
      waitCyc(40);
      chk(wrCnt == snap && !busHold, "R12 stopped", wrCnt, snap);
    end

    chk(protoErr == 0, "R3 strobes only under acknowledge", protoErr, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule